// File: doc/BRIEF.md
# PHY Management Serial Master

This block runs single read and write transactions on a two-wire PHY management bus. The host offers one command: a write-select bit, a 5-bit PHY address, a 5-bit register address and 16 bits of write data. The block accepts it while idle, raises `busy`, and shifts the frame out on its own management clock. When the transaction ends, it pulses `done` for one cycle and, for a read, presents the returned 16-bit word on `rdata`.

The management clock comes from the system clock. A divider sets each half period to `ceil(SYS_CLK_HZ / (2 * MDC_MAX_HZ))` system cycles, so the bus clock never runs faster than `MDC_MAX_HZ`.

The shared data line is driven through an output value and an output enable. The block releases the line whenever the PHY owns it. A run-time input chooses whether a 32-bit all-ones preamble goes before each frame.

Top module: `mdio_master`

## Requirements
- R1: Every management clock bit period is low for exactly HALF system cycles and then high for exactly HALF system cycles. HALF = ceil(SYS_CLK_HZ / (2 * MDC_MAX_HZ)); with the defaults this is 10.
- R2: With `preamble_en` = 1 at acceptance, 32 driven ones come before the frame. With `preamble_en` = 0, the first driven bit is the first frame bit.
- R3: A read drives 16 frame bits, MSB first: `{6'b110110, phy[4:0], reg[4:0]}`.
- R4: After a read frame, the line is released (`mdio_oe` = 0) for 19 clock periods. `mdio_in` is sampled on each rising management clock edge. Number the 19 samples from bit 18 (first) down to bit 0 (last); `rdata` then takes bits 16:1, which drops both turnaround samples and the final idle sample.
- R5: A write drives 32 frame bits, MSB first: `{4'b0101, phy[4:0], reg[4:0], 2'b10, wdata[15:0]}`.
- R6: After a write frame, exactly 2 more clock periods run with the line released.
- R7: `mdio_out` and `mdio_oe` change only while `mdc` is low. They hold steady through every high phase, so each bit is set up before its rising edge.
- R8: `done` is high for exactly one system cycle. That cycle immediately follows the end of the last high phase, and `busy` is already low in it. `rdata` changes only on a read's `done`; a write leaves it unchanged.
- R9: A `cmd_valid` that arrives while `busy` is high is ignored and does not disturb the transaction in progress.
- R10: While idle (after reset or after `done`), `mdc` is low and `mdio_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, accepted when idle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register address |
| cmd_wdata | input | 16 | Write data |
| preamble_en | input | 1 | Send the 32-bit preamble for this command |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Last read result |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Data value driven onto the line |
| mdio_oe | output | 1 | Data line output enable |
| mdio_in | input | 1 | Data line value seen from the bus |

## Verification
The bench runs reads and writes with and without the preamble, at corner addresses and data of all zeros, all ones and mixed patterns. A preamble-off case tells a correct frame apart from one shifted by a stray lead-in. The PHY response words set the turnaround and trailing idle samples to values unlike their neighbours, so a slice off by one bit shows up in `rdata`. A write issued between two reads shows that `rdata` holds. A conflicting command injected mid-frame shows whether a busy request leaks into the bit stream. Phase-length and hold counters during every transaction separate correct clock pacing and setup from off-by-one divider or early data changes.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int PHY_W        = 5;
  localparam int REG_W        = 5;
  localparam int DATA_W       = 16;
  localparam int FRAME_W      = 32;
  localparam int PRE_BITS     = 32;
  localparam int RD_CMD_BITS  = 16;
  localparam int WR_CMD_BITS  = 32;
  localparam int RD_TAIL_BITS = 19;
  localparam int WR_TAIL_BITS = 2;
  localparam int CNT_W        = $clog2(WR_CMD_BITS + 1);

  localparam logic [5:0] RD_LEAD = 6'b110110;
  localparam logic [3:0] WR_LEAD = 4'b0101;
  localparam logic [1:0] WR_TA   = 2'b10;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_PRE,
    PH_CMD,
    PH_TAIL
  } mdio_phase_e;

  function automatic int calc_half(input int sys_hz, input int mdc_hz);
    int h;
    h = (sys_hz + 2 * mdc_hz - 1) / (2 * mdc_hz);
    if (h < 1) h = 1;
    return h;
  endfunction

endpackage

// File: rtl/mdio_tick_gen.sv
module mdio_tick_gen #(
  parameter int HALF = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/mdio_frame_fmt.sv
module mdio_frame_fmt
  import mdio_pkg::*;
(
  input  logic               is_wr,
  input  logic [PHY_W-1:0]   phy,
  input  logic [REG_W-1:0]   regad,
  input  logic [DATA_W-1:0]  wdata,
  output logic [FRAME_W-1:0] frame
);
  always_comb begin
    if (is_wr) begin
      frame = {WR_LEAD, phy, regad, WR_TA, wdata};
    end else begin
      frame = {RD_LEAD, phy, regad, {DATA_W{1'b0}}};
    end
  end
endmodule

// File: rtl/mdio_rx_shift.sv
module mdio_rx_shift #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          en,
  input  logic          din,
  output logic [DW-1:0] word
);
  logic [DW:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      sh_q <= '0;
    end else if (en) begin
      sh_q <= {sh_q[DW-1:0], din};
    end
  end

  assign word = sh_q[DW:1];
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int SYS_CLK_HZ = 50_000_000,
  parameter int MDC_MAX_HZ = 2_500_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [PHY_W-1:0]  cmd_phy,
  input  logic [REG_W-1:0]  cmd_reg,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              preamble_en,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              mdc,
  output logic              mdio_out,
  output logic              mdio_oe,
  input  logic              mdio_in
);
  localparam int HALF = calc_half(SYS_CLK_HZ, MDC_MAX_HZ);

  mdio_phase_e        phase_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] shreg_q;
  logic               wr_q;
  logic               mdc_q;
  logic               out_q;
  logic               oe_q;
  logic               done_q;
  logic [DATA_W-1:0]  rdata_q;

  logic               running;
  logic               tick;
  logic               accept;
  logic               rise_evt;
  logic               fall_evt;
  logic               sample_en;
  logic [FRAME_W-1:0] frame;
  logic [DATA_W-1:0]  rx_word;

  assign running   = (phase_q != PH_IDLE);
  assign accept    = !running && cmd_valid;
  assign rise_evt  = tick && !mdc_q;
  assign fall_evt  = tick && mdc_q;
  assign sample_en = rise_evt && (phase_q == PH_TAIL) && !wr_q;

  mdio_tick_gen #(.HALF(HALF)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (running),
    .tick (tick)
  );

  mdio_frame_fmt u_fmt (
    .is_wr (cmd_write),
    .phy   (cmd_phy),
    .regad (cmd_reg),
    .wdata (cmd_wdata),
    .frame (frame)
  );

  mdio_rx_shift #(.DW(DATA_W)) u_rx (
    .clk   (clk),
    .rst   (rst),
    .clear (accept),
    .en    (sample_en),
    .din   (mdio_in),
    .word  (rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      shreg_q <= '0;
      wr_q    <= 1'b0;
      mdc_q   <= 1'b0;
      out_q   <= 1'b0;
      oe_q    <= 1'b0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        wr_q    <= cmd_write;
        shreg_q <= frame;
        mdc_q   <= 1'b0;
        oe_q    <= 1'b1;
        if (preamble_en) begin
          phase_q <= PH_PRE;
          cnt_q   <= CNT_W'(PRE_BITS - 1);
          out_q   <= 1'b1;
        end else begin
          phase_q <= PH_CMD;
          cnt_q   <= cmd_write ? CNT_W'(WR_CMD_BITS - 1) : CNT_W'(RD_CMD_BITS - 1);
          out_q   <= frame[FRAME_W-1];
        end
      end else if (rise_evt) begin
        mdc_q <= 1'b1;
      end else if (fall_evt) begin
        mdc_q <= 1'b0;
        if (cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
          if (phase_q == PH_CMD) begin
            shreg_q <= shreg_q << 1;
            out_q   <= shreg_q[FRAME_W-2];
          end
        end else begin
          case (phase_q)
            PH_PRE: begin
              phase_q <= PH_CMD;
              cnt_q   <= wr_q ? CNT_W'(WR_CMD_BITS - 1) : CNT_W'(RD_CMD_BITS - 1);
              out_q   <= shreg_q[FRAME_W-1];
            end
            PH_CMD: begin
              phase_q <= PH_TAIL;
              cnt_q   <= wr_q ? CNT_W'(WR_TAIL_BITS - 1) : CNT_W'(RD_TAIL_BITS - 1);
              oe_q    <= 1'b0;
              out_q   <= 1'b0;
            end
            PH_TAIL: begin
              phase_q <= PH_IDLE;
              done_q  <= 1'b1;
              if (!wr_q) rdata_q <= rx_word;
            end
            default: phase_q <= PH_IDLE;
          endcase
        end
      end
    end
  end

  assign busy     = running;
  assign done     = done_q;
  assign rdata    = rdata_q;
  assign mdc      = mdc_q;
  assign mdio_out = out_q;
  assign mdio_oe  = oe_q;
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
  import mdio_pkg::*;
#(
  parameter int SYS_CLK_HZ = 50_000_000,
  parameter int MDC_MAX_HZ = 2_500_000
) (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic mdc,
  input logic mdio_out,
  input logic mdio_oe
);
  localparam int HALF = calc_half(SYS_CLK_HZ, MDC_MAX_HZ);

  logic        prev_mdc;
  logic [31:0] run_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_mdc <= 1'b0;
      run_len  <= '0;
    end else begin
      prev_mdc <= mdc;
      if (mdc != prev_mdc) run_len <= 32'd1;
      else if (run_len != 32'hFFFF_FFFF) run_len <= run_len + 32'd1;
    end
  end

  p_mdc_rate_r1: assert property (@(posedge clk) disable iff (rst)
    (mdc != prev_mdc) |-> (run_len >= 32'(HALF)));

  p_hold_high_r7: assert property (@(posedge clk) disable iff (rst)
    (mdc && prev_mdc) |-> ($stable(mdio_out) && $stable(mdio_oe)));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_idle_lines_r10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdc && !mdio_oe));
endmodule

bind mdio_master mdio_master_chk #(
  .SYS_CLK_HZ (SYS_CLK_HZ),
  .MDC_MAX_HZ (MDC_MAX_HZ)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .done     (done),
  .mdc      (mdc),
  .mdio_out (mdio_out),
  .mdio_oe  (mdio_oe)
);

// File: tb/test_mdio_master.sv
module test_mdio_master;
  localparam int CLK_PERIOD = 10;
  localparam int SYS_HZ     = 50_000_000;
  localparam int MDC_HZ     = 2_500_000;
  localparam int HALF_CYC   = (SYS_HZ + 2 * MDC_HZ - 1) / (2 * MDC_HZ);

  typedef struct {
    logic [63:0] bits;
    int          nbits;
    int          nrel;
    logic        is_wr;
    logic [15:0] rd;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_write = 1'b0;
  logic [4:0]  cmd_phy = '0;
  logic [4:0]  cmd_reg = '0;
  logic [15:0] cmd_wdata = '0;
  logic        preamble_en = 1'b0;
  logic        busy, done, mdc, mdio_out, mdio_oe;
  logic [15:0] rdata;
  logic        mdio_in;

  int total = 0;
  int bad = 0;

  exp_t        q[$];
  logic [18:0] resp = '0;
  logic [63:0] cap_bits = '0;
  int          cap_n = 0;
  int          rel_n = 0;
  int          run = 0;
  bit          run_valid = 1'b0;
  int          len_err = 0;
  int          hold_err = 0;
  logic        mdc_seen = 1'b0;
  logic        out_seen = 1'b0;
  logic        oe_seen = 1'b0;
  bit          after_done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign mdio_in = (rel_n < 19) ? resp[18 - rel_n] : 1'b1;

  mdio_master #(.SYS_CLK_HZ(SYS_HZ), .MDC_MAX_HZ(MDC_HZ)) i_mdio_master (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_phy(cmd_phy), .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata),
    .preamble_en(preamble_en), .busy(busy), .done(done), .rdata(rdata),
    .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  // monitor: samples away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (after_done) begin
        chk(!done, "R8 done width", 64'(done), 64'd0);
        after_done = 1'b0;
      end
      if (mdc && !mdc_seen) begin
        if (mdio_oe) begin
          cap_bits = {cap_bits[62:0], mdio_out};
          cap_n++;
        end else begin
          rel_n++;
        end
      end
      if (mdc && mdc_seen && (mdio_out != out_seen || mdio_oe != oe_seen)) hold_err++;
      if (mdc != mdc_seen) begin
        if (run_valid && run != HALF_CYC) len_err++;
        run = 1;
        run_valid = busy;
      end else begin
        run++;
      end
      mdc_seen = mdc;
      out_seen = mdio_out;
      oe_seen  = mdio_oe;
      if (done) begin
        after_done = 1'b1;
        chk(!busy, "R8 busy at done", 64'(busy), 64'd0);
        if (q.size() == 0) begin
          chk(1'b0, "R8 unexpected done", 64'd1, 64'd0);
        end else begin
          exp_t e;
          logic [63:0] m;
          e = q.pop_front();
          m = (e.nbits == 64) ? '1 : ((64'd1 << e.nbits) - 64'd1);
          chk(cap_n == e.nbits, e.is_wr ? "R2/R5 driven count" : "R2/R3 driven count",
              64'(cap_n), 64'(e.nbits));
          chk((cap_bits & m) == e.bits, e.is_wr ? "R5 frame bits" : "R3 frame bits",
              cap_bits & m, e.bits);
          chk(rel_n == e.nrel, e.is_wr ? "R6 released clocks" : "R4 released clocks",
              64'(rel_n), 64'(e.nrel));
          chk(rdata == e.rd, e.is_wr ? "R8 rdata held" : "R4 rdata",
              64'(rdata), 64'(e.rd));
          chk(len_err == 0, "R1 phase length", 64'(len_err), 64'd0);
          chk(hold_err == 0, "R7 hold while high", 64'(hold_err), 64'd0);
        end
        cap_bits = '0;
        cap_n    = 0;
        rel_n    = 0;
        len_err  = 0;
        hold_err = 0;
      end
    end
  end

  logic [15:0] last_rd = '0;

  // driver: pushes expectations, then issues the command
  task automatic do_cmd(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                        input logic [15:0] wd, input bit pre, input logic [18:0] rsp,
                        input bit poke);
    exp_t e;
    logic [31:0] fr;
    int fl;
    if (wr) begin
      fr = {4'b0101, phy, rg, 2'b10, wd};
      fl = 32;
      e.nrel = 2;
      e.rd = last_rd;
    end else begin
      fr = {16'h0, 6'b110110, phy, rg};
      fl = 16;
      e.nrel = 19;
      e.rd = rsp[16:1];
      last_rd = rsp[16:1];
    end
    if (pre) begin
      e.bits  = ({32'hFFFF_FFFF, 32'h0} >> (32 - fl)) | 64'(fr);
      e.nbits = 32 + fl;
    end else begin
      e.bits  = 64'(fr);
      e.nbits = fl;
    end
    e.is_wr = wr;
    q.push_back(e);
    resp = rsp;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_phy = phy; cmd_reg = rg;
    cmd_wdata = wd; preamble_en = pre;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (poke) begin
      repeat (30) @(negedge clk);
      cmd_valid = 1'b1; cmd_write = ~wr; cmd_phy = ~phy; cmd_reg = ~rg;
      cmd_wdata = ~wd; preamble_en = ~pre;
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(!mdc && !mdio_oe && !busy, "R10 idle after done",
        64'({mdc, mdio_oe, busy}), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL R8 watchdog act=no_done exp=done");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !mdc && !mdio_oe, "R10 reset state",
        64'({busy, done, mdc, mdio_oe}), 64'd0);
    chk(rdata == 16'h0, "R8 reset rdata", 64'(rdata), 64'd0);
    // R2 R3 R4: read with preamble
    do_cmd(1'b0, 5'h01, 5'h01, 16'h0, 1'b1, 19'b10_1100101000111101_0, 1'b0);
    // R3 R4: read without preamble, turnaround and idle opposite to data edges
    do_cmd(1'b0, 5'h1F, 5'h00, 16'h0, 1'b0, 19'b01_0111111111111110_1, 1'b0);
    // R5 R6 R8: write with preamble, rdata must hold
    do_cmd(1'b1, 5'h15, 5'h0A, 16'hA5C3, 1'b1, 19'h7FFFF, 1'b0);
    // R5 R6: write without preamble, all ones data
    do_cmd(1'b1, 5'h00, 5'h1F, 16'hFFFF, 1'b0, 19'h0, 1'b0);
    // R9: busy write with a conflicting command poked mid-frame
    do_cmd(1'b1, 5'h0C, 5'h13, 16'h0000, 1'b0, 19'h0, 1'b1);
    // R9 R4: busy read with poke
    do_cmd(1'b0, 5'h0A, 5'h15, 16'h0, 1'b1, 19'b11_0000000000000001_1, 1'b1);
    // R4: read all-zero data window
    do_cmd(1'b0, 5'h00, 5'h00, 16'h0, 1'b0, 19'b11_0000000000000000_1, 1'b0);
    summary();
    $finish;
  end
endmodule